// File: doc/BRIEF.md
# I2C Bus Timing Compliance Monitor

This block watches the clock and data lines of an I2C bus without driving them. It finds START, repeated START and STOP conditions, measures the intervals between line edges with counters that run on the system clock, and compares each interval with the limit of the speed grade chosen by a mode input. Each broken rule sets its own bit in a violation code. The code and a one-cycle strobe are presented together, and a saturating counter records how many violation cycles have occurred.

Both lines pass through a two-flop synchronizer before any edge is detected. Every limit is written in nanoseconds and converted to a cycle count from the system clock frequency parameter, rounding up. No rule is checked until the first START after reset. After that the monitor keeps track of whether a transfer is open (between a START and a STOP) or the bus is idle.

Top module: `i2c_timing_monitor`

## Requirements
- R1: During and after reset, `viol_stb_o` is 0, `viol_code_o` is 0 and `viol_cnt_o` is 0, and both synchronized lines reset to the idle high level.
- R2: No rule is evaluated before the first START after reset, so SCL pulses of any width and a short idle time before that first START raise no strobe.
- R3: Code bit positions: 0 SCL period, 1 SCL low, 2 SCL high, 3 START hold, 4 repeated-START setup, 5 STOP setup, 6 bus free, 7 data setup, 8 data hold. A violation sets `viol_stb_o` for one cycle, three clock edges after the edge that first samples the offending line change. Rules broken in the same cycle are ORed into one code. The code is 0 whenever the strobe is low.
- R4: SCL low time, measured from an SCL fall to the next SCL rise, must be at least 4.7 µs (standard) or 1.3 µs (fast). An exactly equal interval is legal.
- R5: SCL high time, measured from an SCL rise to the next SCL fall, must be at least 4 µs (standard) or 0.6 µs (fast).
- R6: Within a transfer, the interval between consecutive SCL rises must be at least 10 µs (standard) or 2.5 µs (fast). The first rise after a START or STOP is not measured.
- R7: After a START or repeated START, the next SCL fall must come at least 4 µs (standard) or 0.6 µs (fast) after SDA fell.
- R8: A START seen while a transfer is open is a repeated START. SCL must have been high for at least 4.7 µs (standard) or 0.6 µs (fast) before SDA falls.
- R9: For a STOP (SDA rising while SCL stays high), SCL must have been high for at least 4 µs (standard) or 0.6 µs (fast).
- R10: A START on an idle bus must come at least 4.7 µs (standard) or 1.3 µs (fast) after the previous STOP.
- R11: Inside a transfer, an SCL rise must come at least 250 ns after the last SDA change, in both modes.
- R12: In standard mode only, an SDA change while SCL is low must come no more than 3.45 µs after the SCL fall. Fast mode never reports this rule.
- R13: `mode_i` = 0 selects the standard-mode limits and `mode_i` = 1 selects the fast-mode limits.
- R14: `viol_cnt_o` rises by one for each cycle in which the strobe is high, stays at its all-ones value once it gets there, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; its frequency is the parameter `CLK_MHZ` |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Limit set: 0 standard mode, 1 fast mode |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| viol_stb_o | output | 1 | One-cycle strobe for each cycle with at least one violation |
| viol_code_o | output | 9 | One bit per broken rule, positions as in R3 |
| viol_cnt_o | output | VCNT_W | Saturating count of violation cycles |

## Verification
Frames are built from START, three data bits, an optional repeated START with three more bits, and STOP, and every interval of a frame is a separate knob. Directed frames set a single interval exactly on its limit and one cycle short of it, which separates a strict comparison from an inclusive one and shows that each rule sets only its own bit. The same frame timing is run in both modes, so the standard-only hold rule and the limits that differ between modes are told apart from those shared by both modes. Seeded random frames draw every interval from ranges that straddle the fast-mode limits, and the expected code is computed from the rule table, which exercises combinations of rules broken together.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    // rule indices, equal to the violation code bit positions
    localparam int RULE_PERIOD    = 0;
    localparam int RULE_LOW       = 1;
    localparam int RULE_HIGH      = 2;
    localparam int RULE_STA_HOLD  = 3;
    localparam int RULE_RSTA_SU   = 4;
    localparam int RULE_STO_SU    = 5;
    localparam int RULE_BUS_FREE  = 6;
    localparam int RULE_DAT_SU    = 7;
    localparam int RULE_DAT_HOLD  = 8;
    localparam int NUM_RULES      = 9;

    // interval timers, each restarted by one kind of event
    localparam int TMR_RISE  = 0;
    localparam int TMR_FALL  = 1;
    localparam int TMR_SDA   = 2;
    localparam int TMR_START = 3;
    localparam int TMR_STOP  = 4;
    localparam int NUM_TMRS  = 5;

    // longest limit in nanoseconds, sizes the timers
    localparam int LONGEST_NS = 10000;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda_edge;
        logic scl_low;
        logic start;
        logic stop;
    } bus_ev_t;

    // limit table in nanoseconds: minima except the data hold rule (maximum)
    function automatic int limit_ns(int rule, logic fast);
        int v;
        case (rule)
            RULE_PERIOD:   v = fast ? 2500 : 10000;
            RULE_LOW:      v = fast ? 1300 : 4700;
            RULE_HIGH:     v = fast ? 600  : 4000;
            RULE_STA_HOLD: v = fast ? 600  : 4000;
            RULE_RSTA_SU:  v = fast ? 600  : 4700;
            RULE_STO_SU:   v = fast ? 600  : 4000;
            RULE_BUS_FREE: v = fast ? 1300 : 4700;
            RULE_DAT_SU:   v = 250;
            RULE_DAT_HOLD: v = 3450;
            default:       v = 0;
        endcase
        return v;
    endfunction

    // round a time up to whole clock cycles
    function automatic int ns_to_cyc(int ns, int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    // idle bus level is high, so reset to ones to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/i2cmon_events.sv
module i2cmon_events
    import i2cmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;

        ev_o.scl_rise = scl_s & ~prev_q.scl;
        ev_o.scl_fall = ~scl_s & prev_q.scl;
        ev_o.sda_edge = sda_s ^ prev_q.sda;
        ev_o.scl_low  = ~scl_s & ~prev_q.scl;
        // conditions need SCL steady high across the SDA edge
        ev_o.start    = ~sda_s & prev_q.sda & scl_s & prev_q.scl;
        ev_o.stop     = sda_s & ~prev_q.sda & scl_s & prev_q.scl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/i2cmon_timers.sv
module i2cmon_timers #(
    parameter int NUM = 5,
    parameter int W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM-1:0]         clr_i,
    output logic [NUM-1:0][W-1:0]  t_o
);

    // each timer holds the cycles since its event, loading 1 on the event
    // so that at the next event it equals the distance between the two
    for (genvar i = 0; i < NUM; i++) begin : g_tmr
        logic [W-1:0] cnt_d, cnt_q;

        always_comb begin
            if (clr_i[i]) begin
                cnt_d = W'(1);
            end else if (cnt_q != '1) begin
                cnt_d = cnt_q + W'(1);
            end else begin
                cnt_d = cnt_q;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '1;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign t_o[i] = cnt_q;
    end

endmodule

// File: rtl/i2cmon_rules.sv
module i2cmon_rules
    import i2cmon_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int W       = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fast_i,
    input  bus_ev_t                    ev_i,
    input  logic [NUM_TMRS-1:0][W-1:0] t_i,
    output logic [NUM_RULES-1:0]       viol_o,
    output logic                       armed_o
);

    typedef struct packed {
        logic armed;       // a START has been seen since reset
        logic busy;        // transfer open: START seen, no STOP yet
        logic have_rise;   // an SCL rise seen inside this transfer
        logic start_pend;  // START seen, first SCL fall still to come
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    function automatic logic [W-1:0] lim(int rule, logic fast);
        return W'(ns_to_cyc(limit_ns(rule, fast), CLK_MHZ));
    endfunction

    always_comb begin
        ctl_d  = ctl_q;
        viol_o = '0;

        if (ctl_q.armed) begin
            if (ev_i.scl_rise) begin
                if (ctl_q.have_rise && (t_i[TMR_RISE] < lim(RULE_PERIOD, fast_i)))
                    viol_o[RULE_PERIOD] = 1'b1;
                if (t_i[TMR_FALL] < lim(RULE_LOW, fast_i))
                    viol_o[RULE_LOW] = 1'b1;
                if (ctl_q.busy && (t_i[TMR_SDA] < lim(RULE_DAT_SU, fast_i)))
                    viol_o[RULE_DAT_SU] = 1'b1;
            end
            if (ev_i.scl_fall) begin
                if (t_i[TMR_RISE] < lim(RULE_HIGH, fast_i))
                    viol_o[RULE_HIGH] = 1'b1;
                if (ctl_q.start_pend && (t_i[TMR_START] < lim(RULE_STA_HOLD, fast_i)))
                    viol_o[RULE_STA_HOLD] = 1'b1;
            end
            if (ev_i.start) begin
                if (ctl_q.busy) begin
                    if (t_i[TMR_RISE] < lim(RULE_RSTA_SU, fast_i))
                        viol_o[RULE_RSTA_SU] = 1'b1;
                end else begin
                    if (t_i[TMR_STOP] < lim(RULE_BUS_FREE, fast_i))
                        viol_o[RULE_BUS_FREE] = 1'b1;
                end
            end
            if (ev_i.stop && (t_i[TMR_RISE] < lim(RULE_STO_SU, fast_i)))
                viol_o[RULE_STO_SU] = 1'b1;
            if (ev_i.sda_edge && ev_i.scl_low && ctl_q.busy && !fast_i &&
                (t_i[TMR_FALL] > lim(RULE_DAT_HOLD, 1'b0)))
                viol_o[RULE_DAT_HOLD] = 1'b1;
        end

        if (ev_i.scl_rise) ctl_d.have_rise  = 1'b1;
        if (ev_i.scl_fall) ctl_d.start_pend = 1'b0;
        if (ev_i.start) begin
            ctl_d.armed      = 1'b1;
            ctl_d.busy       = 1'b1;
            ctl_d.start_pend = 1'b1;
            ctl_d.have_rise  = 1'b0;
        end
        if (ev_i.stop) begin
            ctl_d.busy       = 1'b0;
            ctl_d.have_rise  = 1'b0;
            ctl_d.start_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign armed_o = ctl_q.armed;

endmodule

// File: rtl/i2c_timing_monitor.sv
module i2c_timing_monitor
    import i2cmon_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int VCNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 viol_stb_o,
    output logic [NUM_RULES-1:0] viol_code_o,
    output logic [VCNT_W-1:0]    viol_cnt_o
);

    localparam int MAX_CYC = ns_to_cyc(LONGEST_NS, CLK_MHZ);
    localparam int CNT_W   = $clog2(MAX_CYC + 2) + 1;

    typedef struct packed {
        logic                 stb;
        logic [NUM_RULES-1:0] code;
        logic [VCNT_W-1:0]    cnt;
    } out_t;

    logic [1:0]                        lines_s;
    bus_ev_t                           ev;
    logic [NUM_TMRS-1:0]               tmr_clr;
    logic [NUM_TMRS-1:0][CNT_W-1:0]    tmr_val;
    logic [NUM_RULES-1:0]              viol;
    logic                              armed_w;
    out_t                              out_d, out_q;

    i2cmon_sync #(.WIDTH(2), .STAGES(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (lines_s)
    );

    i2cmon_events events_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev_o  (ev)
    );

    always_comb begin
        tmr_clr           = '0;
        tmr_clr[TMR_RISE]  = ev.scl_rise;
        tmr_clr[TMR_FALL]  = ev.scl_fall;
        tmr_clr[TMR_SDA]   = ev.sda_edge;
        tmr_clr[TMR_START] = ev.start;
        tmr_clr[TMR_STOP]  = ev.stop;
    end

    i2cmon_timers #(.NUM(NUM_TMRS), .W(CNT_W)) timers_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .t_o   (tmr_val)
    );

    i2cmon_rules #(.CLK_MHZ(CLK_MHZ), .W(CNT_W)) rules_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_i  (mode_i),
        .ev_i    (ev),
        .t_i     (tmr_val),
        .viol_o  (viol),
        .armed_o (armed_w)
    );

    always_comb begin
        out_d      = out_q;
        out_d.stb  = |viol;
        out_d.code = viol;
        if ((|viol) && (out_q.cnt != '1)) begin
            out_d.cnt = out_q.cnt + VCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign viol_stb_o  = out_q.stb;
    assign viol_code_o = out_q.code;
    assign viol_cnt_o  = out_q.cnt;

endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker
    import i2cmon_pkg::*;
#(
    parameter int VCNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mode,
    input logic                 stb,
    input logic [NUM_RULES-1:0] code,
    input logic [VCNT_W-1:0]    cnt,
    input logic                 armed
);

    localparam logic [VCNT_W-1:0] CNT_MAX = '1;

    assert_code_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (code != '0));

    assert_armed_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> $past(armed));

    assert_hold_std_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        code[RULE_DAT_HOLD] |-> !$past(mode));

    assert_count_step_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ($past(cnt) != CNT_MAX)) |-> (cnt == $past(cnt) + VCNT_W'(1)));

    assert_count_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> (cnt == $past(cnt)));

    assert_count_sat_R14: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == CNT_MAX) |-> (cnt == CNT_MAX));

endmodule

bind i2c_timing_monitor i2cmon_checker #(.VCNT_W(VCNT_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode_i),
    .stb   (viol_stb_o),
    .code  (viol_code_o),
    .cnt   (viol_cnt_o),
    .armed (armed_w)
);

// File: tb/i2c_timing_monitor_tb_top.sv
`timescale 1ns/1ps
module i2c_timing_monitor_tb_top;

    localparam int CNT_SAT = 15;   // bench uses a 4-bit counter
    localparam int FLUSH   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b1;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       stb;
    logic [8:0] code;
    logic [3:0] cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [8:0] acc_code = '0;
    int         seg_stb  = 0;
    int         tot_stb  = 0;

    // frame timing knobs in cycles of the 5 ns clock
    int t_buf, t_hs, t_lo, t_hi, t_hd, t_so, t_sa;
    bit rep;

    always #2.5 clk = ~clk;

    i2c_timing_monitor #(.CLK_MHZ(200), .VCNT_W(4)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .scl_i       (scl),
        .sda_i       (sda),
        .viol_stb_o  (stb),
        .viol_code_o (code),
        .viol_cnt_o  (cnt)
    );

    always @(negedge clk) begin
        if (rst_n && stb) begin
            acc_code = acc_code | code;
            seg_stb  = seg_stb + 1;
            tot_stb  = tot_stb + 1;
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // expected code from the rule table (limits in 5 ns cycles)
    function automatic logic [8:0] exp_code(bit fast);
        logic [8:0] e = '0;
        int lo_l = fast ? 260 : 940;
        int hi_l = fast ? 120 : 800;
        int pe_l = fast ? 500 : 2000;
        int hs_l = fast ? 120 : 800;
        int sa_l = fast ? 120 : 940;
        int so_l = fast ? 120 : 800;
        int bf_l = fast ? 260 : 940;
        if (t_lo + t_hi < pe_l)              e[0] = 1'b1; // R6
        if (t_lo < lo_l)                     e[1] = 1'b1; // R4
        if (t_hi < hi_l)                     e[2] = 1'b1; // R5
        if (rep && (t_sa + t_hs < hi_l))     e[2] = 1'b1;
        if (t_hs < hs_l)                     e[3] = 1'b1; // R7
        if (rep && (t_sa < sa_l))            e[4] = 1'b1; // R8
        if (t_so < so_l)                     e[5] = 1'b1; // R9
        if (t_buf < bf_l)                    e[6] = 1'b1; // R10
        if (t_lo - t_hd < 50)                e[7] = 1'b1; // R11
        if (!fast && (t_hd > 690))           e[8] = 1'b1; // R12
        return e;
    endfunction

    task automatic data_bits();
        for (int i = 0; i < 3; i++) begin
            wt(t_hd); sda = (i != 1);
            wt(t_lo - t_hd); scl = 1'b1;
            wt(t_hi); scl = 1'b0;
        end
    endtask

    task automatic frame();
        wt(t_buf - FLUSH); sda = 1'b0;
        wt(t_hs); scl = 1'b0;
        data_bits();
        if (rep) begin
            wt(t_hd); sda = 1'b1;
            wt(t_lo - t_hd); scl = 1'b1;
            wt(t_sa); sda = 1'b0;
            wt(t_hs); scl = 1'b0;
            data_bits();
        end
        wt(t_hd); sda = 1'b0;
        wt(t_lo - t_hd); scl = 1'b1;
        wt(t_so); sda = 1'b1;
        wt(FLUSH);
    endtask

    task automatic seg_check(logic [8:0] e, string tag);
        int sat;
        chk(acc_code == e, tag, "code", int'(acc_code), int'(e));
        chk((seg_stb != 0) == (e != 0), tag, "strobe seen", seg_stb, int'(e != 0));
        sat = (tot_stb > CNT_SAT) ? CNT_SAT : tot_stb;
        chk(int'(cnt) == sat, "R14", "count", int'(cnt), sat);
        acc_code = '0;
        seg_stb  = 0;
    endtask

    task automatic fast_base();
        mode = 1'b1; rep = 1'b0;
        t_buf = 300; t_hs = 150; t_lo = 300; t_hi = 220; t_hd = 20; t_so = 150; t_sa = 150;
    endtask

    task automatic std_base();
        mode = 1'b0; rep = 1'b0;
        t_buf = 1000; t_hs = 850; t_lo = 1000; t_hi = 1000; t_hd = 20; t_so = 850; t_sa = 1000;
    endtask

    task automatic run(string tag);
        frame();
        seg_check(exp_code(mode), tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_1234);
        wt(5);
        chk(stb == 1'b0, "R1", "strobe in reset", int'(stb), 0);
        rst_n = 1'b1;
        wt(4);
        chk(stb == 1'b0 && code == '0, "R1", "outputs after reset", int'(code), 0);
        chk(cnt == '0, "R1", "count after reset", int'(cnt), 0);

        // R2: narrow SCL pulses with no START, then a START after a short idle
        for (int i = 0; i < 6; i++) begin
            scl = 1'b0; wt(3); scl = 1'b1; wt(3);
        end
        wt(FLUSH);
        seg_check('0, "R2");
        fast_base(); t_buf = 20;
        frame();
        seg_check('0, "R2");

        // R3: legal fast frames, with and without repeated START
        fast_base(); run("R3");
        fast_base(); rep = 1'b1; run("R3");

        // R4: low time at the limit and one cycle short
        fast_base(); t_lo = 260; t_hi = 240; run("R4");
        fast_base(); t_lo = 259; t_hi = 241; run("R4");
        // R5: high time at the limit and one cycle short
        fast_base(); t_lo = 400; t_hi = 120; run("R5");
        fast_base(); t_lo = 400; t_hi = 119; run("R5");
        // R6: low and high legal, period short
        fast_base(); t_lo = 270; t_hi = 200; run("R6");
        // R7: START hold short
        fast_base(); t_hs = 100; run("R7");
        // R8: repeated START setup short, and on the limit
        fast_base(); rep = 1'b1; t_sa = 100; run("R8");
        fast_base(); rep = 1'b1; t_sa = 120; run("R8");
        // R9: STOP setup short
        fast_base(); t_so = 119; run("R9");
        // R10: bus free short, and on the limit
        fast_base(); t_buf = 200; run("R10");
        fast_base(); t_buf = 260; run("R10");
        // R11: data setup short (SDA change 40 cycles before SCL rise)
        fast_base(); t_hd = 260; run("R11");
        // R3: several rules in the same cycle are ORed
        fast_base(); t_lo = 100; run("R3");

        // R13: standard mode legal, then fast-legal low time in standard mode
        std_base(); t_buf = 1200; run("R13");
        std_base(); t_lo = 500; run("R13");
        // R12: late data change flagged only in standard mode
        std_base(); t_lo = 1200; t_hd = 700; run("R12");
        fast_base(); t_buf = 1200; t_lo = 1200; t_hd = 700; run("R12");
        // R13: same fast-legal low time in fast mode
        fast_base(); t_lo = 500; run("R13");

        // random frames around the fast-mode limits
        for (int n = 0; n < 12; n++) begin
            fast_base();
            rep   = $urandom_range(1, 0) == 1;
            t_lo  = $urandom_range(340, 240);
            t_hi  = $urandom_range(200, 100);
            t_hs  = $urandom_range(160, 100);
            t_sa  = $urandom_range(160, 100);
            t_so  = $urandom_range(160, 100);
            t_buf = $urandom_range(320, 240);
            if ($urandom_range(4, 0) == 0) t_hd = t_lo - $urandom_range(70, 30);
            else                          t_hd = $urandom_range(40, 1);
            run("R3");
        end

        // R14: by now the count has passed 15 and must sit there
        chk(cnt == 4'hF, "R14", "saturated count", int'(cnt), 15);
        chk(tot_stb > CNT_SAT, "R14", "enough strobes", tot_stb, CNT_SAT + 1);

        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule